// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a 7-bit down-counter that must be reloaded inside a time window. The counter decrements on a slow tick taken from the bus clock: the clock is divided by a fixed power of two (4096 by default) and then by 1, 2, 4 or 8, as a 2-bit prescale code selects. Until software sets the arm bit, the counter is frozen and the block stays silent. Once armed, the block cannot be disarmed except by system reset.

While armed, the block raises a one-cycle reset request in three cases. The first is when the count decrements from 0x40 to 0x3F, which is the moment bit 6 clears. The second is when software reloads the counter while the count is still above the programmed window limit. The third is when software loads a value whose bit 6 is clear, either while the block is armed or in the same write that arms it. One tick before expiry, as the count enters 0x40, an early-warning status flag is set. The interrupt output is this flag gated by an interrupt enable that can only be set, never cleared, until system reset.

Software talks to the block through a simple write port plus a registered read port decoded by a 2-bit register select. The reset request and the interrupt go out to the chip's reset and interrupt controllers.

Top module: `window_watchdog`

## Requirements
- R1: After system reset, the control register reads 0x7F (count 0x7F, arm bit 0), the config register reads 0x07F (limit 0x7F, prescale 0, interrupt enable 0), status reads 0, and `rst_req` and `early_irq` are low.
- R2: While not armed, the count never decrements and `rst_req` stays low. A control write without the arm bit loads bits 6:0 into the count with no window check.
- R3: While armed, the count decrements once every 2^DIV_LOG2 × 2^p bus cycles, where p is the prescale code in config bits 8:7. The first decrement falls that many cycles after the arming write.
- R4: When an armed count decrements from 0x40 to 0x3F, `rst_req` is high for exactly the one cycle after that edge.
- R5: A control write while armed raises `rst_req` in the following cycle if the count just before the write is greater than the window limit (config bits 6:0). A count equal to or below the limit raises no request.
- R6: A control write that leaves the block armed and loads a value with bit 6 clear raises `rst_req` in the following cycle.
- R7: The arm bit is control bit 7. Writing 1 sets it. Writing 0 leaves it set.
- R8: The early-warning flag is status bit 0. It is set by the decrement that makes the count 0x40. Writing status with bit 0 = 0 clears it, and writing bit 0 = 1 has no effect.
- R9: The interrupt enable is config bit 9 and can only be set by writes. `early_irq` is high exactly when both the flag and the enable are set.
- R10: `reg_rdata` updates every cycle with the register picked by `reg_addr` (0 control, 1 config, 2 status, 3 reads 0), and shows its contents as they were before that clock edge. Unused high bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_addr | input | 2 | Register select: 0 control, 1 config, 2 status |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Registered read data of the selected register |
| rst_req | output | 1 | One-cycle system reset request |
| early_irq | output | 1 | Early-warning interrupt |

## Verification
Directed sequences let the count run out under two prescale codes. These measure the exact cycle of the expiry pulse, so they separate a wrong tick period or an off-by-one terminal count from correct behaviour. Reloads are issued with the count above, equal to and below the window limit, which isolates the window comparison, including its boundary. Separate tests load a value below 0x40 and try to clear the set-only bits. A long random phase mixes reloads, limit and prescale changes, flag clears and reads against a cycle model. It covers reloads that coincide with a tick and clears that coincide with the flag setting.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  // Register select codes carried on reg_addr.
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Status register: bit position of the early-warning flag.
  localparam int unsigned STAT_FLAG_BIT = 0;

endpackage

// File: rtl/wdw_tick_gen.sv
// Divides the bus clock into a one-cycle decrement enable.
// The division is 2**(DIV_LOG2 + psc). The divider restarts at arming.
module wdw_tick_gen #(
  parameter int unsigned DIV_LOG2 = 12,
  parameter int unsigned PSC_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);

  localparam int unsigned NCODES = 1 << PSC_W;
  localparam int unsigned DIV_W  = DIV_LOG2 + NCODES;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim_tab [NCODES];
  logic [DIV_W-1:0] lim_m1;

  // One terminal value per prescale code.
  for (genvar i = 0; i < NCODES; i++) begin : g_lim
    assign lim_tab[i] = DIV_W'((64'd1 << (DIV_LOG2 + i)) - 64'd1);
  end

  assign lim_m1 = lim_tab[psc];
  assign tick   = run && (div_q >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/wdw_down_counter.sv
// Holds the count and the arm bit. Decides when a reset request is due.
module wdw_down_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_arm,
  input  logic             tick,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt_q,
  output logic             arm_q,
  output logic             restart,
  output logic             expire,
  output logic             early_set
);

  localparam logic [CNT_W-1:0] THR     = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] THR_P1  = THR + CNT_W'(1);
  localparam int unsigned      MSB     = CNT_W - 1;

  logic [CNT_W-1:0] cnt_d;
  logic             arm_d;

  assign restart = ctrl_wr && wr_arm && !arm_q;

  always_comb begin
    cnt_d     = cnt_q;
    arm_d     = arm_q;
    expire    = 1'b0;
    early_set = 1'b0;
    if (ctrl_wr) begin
      // Reload outside the window is a violation.
      if (arm_q && (cnt_q > win)) expire = 1'b1;
      arm_d = arm_q | wr_arm;
      // Loading a value already past the threshold while armed.
      if (arm_d && !wr_cnt[MSB]) expire = 1'b1;
      cnt_d = wr_cnt;
    end else if (tick) begin
      if (cnt_q == THR)    expire    = 1'b1;
      if (cnt_q == THR_P1) early_set = 1'b1;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      arm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

endmodule

// File: rtl/wdw_regfile.sv
// Config and status registers, interrupt output and registered read mux.
module wdw_regfile
  import wdw_pkg::*;
#(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned PSC_W  = 2,
  parameter int unsigned DATA_W = CNT_W + PSC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  reg_sel_e          sel,
  input  logic              early_set,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              arm_q,
  output logic [CNT_W-1:0]  win_q,
  output logic [PSC_W-1:0]  psc_q,
  output logic              ewi_q,
  output logic              flag_q,
  output logic              irq_q,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int unsigned PSC_LSB = CNT_W;
  localparam int unsigned EWI_BIT = CNT_W + PSC_W;

  logic              flag_d;
  logic              ewi_d;
  logic [DATA_W-1:0] rd_d;

  assign ewi_d = ewi_q | (cfg_wr && wdata[EWI_BIT]);

  always_comb begin
    flag_d = flag_q;
    if (stat_wr && !wdata[STAT_FLAG_BIT]) flag_d = 1'b0;
    if (early_set)                        flag_d = 1'b1;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_d = {{(DATA_W - CNT_W - 1){1'b0}}, arm_q, cnt_q};
      SEL_CFG:  rd_d = {ewi_q, psc_q, win_q};
      SEL_STAT: rd_d = {{(DATA_W - 1){1'b0}}, flag_q};
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '1;
      psc_q   <= '0;
      ewi_q   <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cfg_wr) begin
        win_q <= wdata[CNT_W-1:0];
        psc_q <= wdata[PSC_LSB +: PSC_W];
      end
      ewi_q   <= ewi_d;
      flag_q  <= flag_d;
      irq_q   <= flag_d && ewi_d;
      rdata_q <= rd_d;
    end
  end

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdw_pkg::*;
#(
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned PSC_W    = 2,
  parameter int unsigned DIV_LOG2 = 12,
  localparam int unsigned DATA_W  = CNT_W + PSC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rst_req,
  output logic              early_irq
);

  reg_sel_e         sel;
  logic             ctrl_wr, cfg_wr, stat_wr;
  logic [CNT_W-1:0] cnt_q, win_q;
  logic [PSC_W-1:0] psc_q;
  logic             arm_q, ewi_q, flag_q;
  logic             tick, restart, expire, early_set;

  assign sel     = reg_sel_e'(reg_addr);
  assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
  assign cfg_wr  = reg_wr && (sel == SEL_CFG);
  assign stat_wr = reg_wr && (sel == SEL_STAT);

  wdw_tick_gen #(
    .DIV_LOG2 (DIV_LOG2),
    .PSC_W    (PSC_W)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (arm_q),
    .restart (restart),
    .psc     (psc_q),
    .tick    (tick)
  );

  wdw_down_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .wr_cnt    (reg_wdata[CNT_W-1:0]),
    .wr_arm    (reg_wdata[CNT_W]),
    .tick      (tick),
    .win       (win_q),
    .cnt_q     (cnt_q),
    .arm_q     (arm_q),
    .restart   (restart),
    .expire    (expire),
    .early_set (early_set)
  );

  wdw_regfile #(
    .CNT_W  (CNT_W),
    .PSC_W  (PSC_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .stat_wr   (stat_wr),
    .wdata     (reg_wdata),
    .sel       (sel),
    .early_set (early_set),
    .cnt_q     (cnt_q),
    .arm_q     (arm_q),
    .win_q     (win_q),
    .psc_q     (psc_q),
    .ewi_q     (ewi_q),
    .flag_q    (flag_q),
    .irq_q     (early_irq),
    .rdata_q   (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= expire;
  end

endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rst_req,
  input logic              early_irq,
  input logic              arm_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              tick,
  input logic              flag_q,
  input logic              ewi_q
);

  localparam logic [CNT_W-1:0] THR = CNT_W'(1 << (CNT_W - 1));

  logic ctrl_w;
  assign ctrl_w = reg_wr && (reg_addr == 2'd0);

  // R2: an unarmed block that is not being armed raises no request
  assert_quiet_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
    (!arm_q && !(ctrl_w && reg_wdata[CNT_W])) |=> !rst_req);

  // R2: an unarmed count only changes through a control write
  assert_frozen_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
    (!arm_q && !ctrl_w) |=> $stable(cnt_q));

  // R4: a tick at the threshold leads to a request
  assert_expiry_request_R4: assert property (@(posedge clk) disable iff (rst)
    (arm_q && tick && (cnt_q == THR) && !ctrl_w) |=> rst_req);

  // R4: requests only come from an armed block
  assert_request_armed_R4: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> arm_q);

  // R7: arm bit is sticky
  assert_arm_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    arm_q |=> arm_q);

  // R8: flag rises only as the count lands on the threshold
  assert_flag_at_threshold_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (cnt_q == THR));

  // R9: interrupt enable is sticky and the interrupt needs the flag
  assert_ewi_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ewi_q |=> ewi_q);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    early_irq |-> (flag_q && ewi_q));

endmodule

bind window_watchdog window_watchdog_chk #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rst_req   (rst_req),
  .early_irq (early_irq),
  .arm_q     (arm_q),
  .cnt_q     (cnt_q),
  .tick      (tick),
  .flag_q    (flag_q),
  .ewi_q     (ewi_q)
);

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DL = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [9:0] reg_wdata;
  logic [9:0] reg_rdata;
  logic       rst_req;
  logic       early_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  window_watchdog #(.CNT_W(7), .PSC_W(2), .DIV_LOG2(DL)) u_window_watchdog (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .early_irq(early_irq)
  );

  // Cycle model of the requirements
  logic       m_arm, m_ewi, m_flag;
  logic [6:0] m_cnt, m_win;
  logic [1:0] m_psc;
  int         m_div;
  logic       e_req, e_irq;
  logic [9:0] e_rd;

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic r, input logic w, input logic [1:0] a,
                            input logic [9:0] d);
    logic tk, trig, setf, rs, narm;
    logic [6:0] ncnt;
    int lim;
    if (r) begin
      m_arm = 0; m_ewi = 0; m_flag = 0; m_cnt = 7'h7F; m_win = 7'h7F;
      m_psc = 0; m_div = 0; e_req = 0; e_irq = 0; e_rd = 0;
      return;
    end
    case (a)
      2'd0:    e_rd = {2'b0, m_arm, m_cnt};
      2'd1:    e_rd = {m_ewi, m_psc, m_win};
      2'd2:    e_rd = {9'b0, m_flag};
      default: e_rd = 0;
    endcase
    lim  = 1 << (DL + m_psc);
    tk   = m_arm && (m_div >= lim - 1);
    trig = 0; setf = 0; rs = 0; narm = m_arm; ncnt = m_cnt;
    if (w && a == 2'd0) begin
      if (m_arm && m_cnt > m_win) trig = 1;
      if (!m_arm && d[7]) rs = 1;
      narm = m_arm | d[7];
      if (narm && !d[6]) trig = 1;
      ncnt = d[6:0];
    end else if (tk) begin
      if (m_cnt == 7'h40) trig = 1;
      if (m_cnt == 7'h41) setf = 1;
      ncnt = m_cnt - 7'd1;
    end
    if (rs) m_div = 0;
    else if (m_arm) m_div = tk ? 0 : m_div + 1;
    if (w && a == 2'd1) begin
      m_win = d[6:0]; m_psc = d[8:7]; m_ewi = m_ewi | d[9];
    end
    if (w && a == 2'd2 && !d[0]) m_flag = 0;
    if (setf) m_flag = 1;
    m_arm = narm; m_cnt = ncnt;
    e_req = trig;
    e_irq = m_flag && m_ewi;
  endtask

  // One bus cycle: drive at the falling edge, check at the next falling edge.
  task automatic cyc(input logic r, input logic w, input logic [1:0] a, input logic [9:0] d);
    rst = r; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_step(r, w, a, d);
    @(negedge clk);
    chk("R4 R5 R6 rst_req", rst_req, e_req);
    chk("R9 early_irq", early_irq, e_irq);
    chk("R10 reg_rdata", reg_rdata, e_rd);
  endtask

  task automatic do_reset();
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(0, 0, a, 0);
  endtask

  task automatic cycles_to_req(output int n);
    n = 0;
    for (int i = 1; i <= 400; i++) begin
      cyc(0, 0, 0, 0);
      if (rst_req) begin n = i; break; end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int n;
    void'($urandom(32'd4711));
    do_reset();

    // R1 reset state
    chk("R1 rst_req", rst_req, 0);
    chk("R1 early_irq", early_irq, 0);
    cyc(0, 0, 0, 0); chk("R1 ctrl", reg_rdata, 10'h07F);
    cyc(0, 0, 1, 0); chk("R1 cfg", reg_rdata, 10'h07F);
    cyc(0, 0, 2, 0); chk("R1 status", reg_rdata, 0);
    cyc(0, 0, 3, 0); chk("R10 unused select", reg_rdata, 0);

    // R2 unarmed: no window check, no decrement
    cyc(0, 1, 1, 10'h040);
    cyc(0, 1, 0, 10'h070);
    chk("R2 no window check unarmed", rst_req, 0);
    idle(40, 0);
    chk("R2 frozen count", reg_rdata, 10'h070);

    // R3 R4 expiry timing, prescale 0: 3 ticks of 4 cycles
    do_reset();
    cyc(0, 1, 0, 10'h0C2);
    cycles_to_req(n);
    chk("R3 R4 expiry cycle psc0", n, 12);
    cyc(0, 0, 0, 0);
    chk("R4 single-cycle pulse", rst_req, 0);

    // R3 prescale 1: 2 ticks of 8 cycles
    do_reset();
    cyc(0, 1, 1, 10'h0FF);
    cyc(0, 1, 0, 10'h0C1);
    cycles_to_req(n);
    chk("R3 expiry cycle psc1", n, 16);

    // R5 early reload
    do_reset();
    cyc(0, 1, 1, 10'h050);
    cyc(0, 1, 0, 10'h0FF);
    chk("R5 arming write not checked", rst_req, 0);
    cyc(0, 1, 0, 10'h0FF);
    chk("R5 reload above limit", rst_req, 1);
    do_reset();
    cyc(0, 1, 1, 10'h060);
    cyc(0, 1, 0, 10'h0E0);
    cyc(0, 1, 0, 10'h0E0);
    chk("R5 reload at limit", rst_req, 0);

    // R6 load below threshold while arming
    do_reset();
    cyc(0, 1, 0, 10'h0BF);
    chk("R6 low load", rst_req, 1);

    // R7 arm bit sticky
    do_reset();
    cyc(0, 1, 0, 10'h0FF);
    cyc(0, 1, 0, 10'h07F);
    cyc(0, 0, 0, 0);
    chk("R7 arm sticky", reg_rdata, 10'h0FF);

    // R8 R9 early warning
    do_reset();
    cyc(0, 1, 1, 10'h27F);
    cyc(0, 1, 0, 10'h0C2);
    idle(7, 0);
    chk("R8 flag not yet", early_irq, 0);
    cyc(0, 0, 0, 0);
    chk("R8 R9 irq at 0x40", early_irq, 1);
    cyc(0, 1, 1, 10'h07F);
    cyc(0, 0, 1, 0);
    chk("R9 enable sticky", reg_rdata, 10'h27F);
    cyc(0, 1, 2, 10'h001);
    cyc(0, 0, 2, 0);
    chk("R8 write 1 ignored", reg_rdata, 1);
    cyc(0, 1, 2, 10'h000);
    chk("R8 R9 cleared irq", early_irq, 0);
    cyc(0, 0, 2, 0);
    chk("R8 cleared flag", reg_rdata, 0);

    // Random phase against the model
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      int x;
      logic [9:0] d;
      x = $urandom % 100;
      if (e_req || x == 99) begin
        cyc(1, 0, 0, 0);
      end else if (x < 4) begin
        d = {2'b0, 1'($urandom % 4 == 0), 1'($urandom % 10 != 0), 6'($urandom)};
        cyc(0, 1, 0, d);
      end else if (x < 6) begin
        d = {1'($urandom % 2), 2'($urandom), 1'($urandom % 8 != 0), 6'($urandom)};
        cyc(0, 1, 1, d);
      end else if (x < 8) begin
        cyc(0, 1, 2, 10'($urandom % 2));
      end else begin
        cyc(0, 0, 2'($urandom), 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule